// File: doc/BRIEF.md
# Status Register and Write-Protect Unit

This block holds the 8-bit status byte of a serial memory device and decides whether a write may proceed. It combines four sources of protection: the write-enable latch, a two-bit block-protect level, a stored pin-enable bit, and an active-low external write-protect pin. The serial front end feeds it decoded commands (latch set, latch clear, status write with its data byte) together with the chip-select state. The array timer supplies a busy flag. In return the block gives the status byte for read-back, a start pulse when a status write commits, and a combinational permit flag for any array address under test.

The array holds 2048 bytes and is protected in blocks counted from the top of the address space. A status write is staged while chip select is low and commits on its rising edge. If the external pin asserts protection before that edge, the staged write is dropped. Once the commit has happened, the pin no longer affects it. Whenever the internal write cycle ends, the enable latch returns to 0.

Top module: `sr_guard`

## Requirements
- R1: After reset the status byte reads 0x00 and the permit output is 0.
- R2: A set command makes status bit 1 (write-enable) read 1. A clear command makes it read 0. When both arrive in the same cycle, clear wins.
- R3: While `busy_i` is high the status byte reads 0xFF. Otherwise it reads {pin-enable, 3'b000, level[1:0], write-enable, 1'b0}, with bits 6 to 4 always 0.
- R4: The level field (status bits 3:2) selects the protected range: 00 protects nothing, 01 protects 0x600–0x7FF, 10 protects 0x400–0x7FF, and 11 protects 0x000–0x7FF.
- R5: `wr_permit_o` is 1 exactly when the write-enable latch is set and `chk_addr_i` lies outside the protected range.
- R6: A status write request is staged only when chip select is low, the latch is set, `busy_i` is low and hardware protection is off. On the next rising edge of chip select, `sr_start_o` pulses for that cycle and status bits 7 and 3:2 take the staged data bits 7 and 3:2. No other event changes those bits.
- R7: Hardware protection is on only while the pin-enable bit (status bit 7) is 1 and `wp_ni` is low. When the pin-enable bit is 0, `wp_ni` has no effect.
- R8: If hardware protection comes on while chip select is still low, the staged status write is discarded and no start pulse follows. A commit that has already happened is not affected by the pin.
- R9: While `busy_i` is high, set and clear commands are ignored. In the cycle after `busy_i` falls, the write-enable latch reads 0.
- R10: While hardware protection is on, the pin-enable bit cannot be written back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wel_set_i | input | 1 | Decoded set-latch command, one-cycle pulse |
| wel_clr_i | input | 1 | Decoded clear-latch command, one-cycle pulse |
| sr_wr_req_i | input | 1 | Status write data byte complete, one-cycle pulse |
| sr_wr_data_i | input | 8 | Status write data byte |
| cs_ni | input | 1 | Chip select, active low |
| wp_ni | input | 1 | Write-protect pin, active low |
| busy_i | input | 1 | Internal write cycle in progress |
| chk_addr_i | input | 11 | Array address to be checked |
| wr_permit_o | output | 1 | Array write allowed at `chk_addr_i` |
| sr_start_o | output | 1 | Status write commits this cycle |
| status_o | output | 8 | Status byte for read-back |

## Verification
A write-enable latch stuck or cleared at the wrong time shows on status bit 1 one cycle after the command. It also shows at once on `wr_permit_o` for any unprotected address. A wrong staging or abort decision shows as a missing or spurious `sr_start_o` in the cycle chip select rises, and as a wrong level or pin-enable field once the following busy window closes. The reference model predicts all three outputs in every cycle, so a divergence is reported in the cycle it first appears.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;
  typedef enum logic [1:0] {
    PROT_NONE    = 2'b00,
    PROT_QUARTER = 2'b01,
    PROT_HALF    = 2'b10,
    PROT_ALL     = 2'b11
  } prot_lvl_e;

  localparam int unsigned SR_W      = 8;
  localparam int unsigned SR_PEN    = 7;
  localparam int unsigned SR_LVL_HI = 3;
  localparam int unsigned SR_LVL_LO = 2;
  localparam int unsigned SR_WEN    = 1;

  function automatic logic [SR_W-1:0] pack_status(logic pen, prot_lvl_e lvl, logic wen);
    logic [SR_W-1:0] s;
    s = '0;
    s[SR_PEN] = pen;
    s[SR_LVL_HI:SR_LVL_LO] = lvl;
    s[SR_WEN] = wen;
    return s;
  endfunction
endpackage

// File: rtl/sr_wel.sv
module sr_wel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic busy_i,
  input  logic busy_fall_i,
  output logic wen_o
);
  logic wen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          wen_q <= 1'b0;
    else if (busy_fall_i) wen_q <= 1'b0;
    else if (!busy_i) begin
      if (clr_i)      wen_q <= 1'b0;
      else if (set_i) wen_q <= 1'b1;
    end
  end

  assign wen_o = wen_q;

  a_r9_cleared_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_fall_i |=> !wen_o);
  a_r9_hold_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(wen_o));
  a_r2_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !busy_i) |=> !wen_o);
endmodule

// File: rtl/sr_commit.sv
module sr_commit
  import sr_guard_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cs_ni,
  input  logic      req_i,
  input  logic      pen_data_i,
  input  prot_lvl_e lvl_data_i,
  input  logic      wen_i,
  input  logic      busy_i,
  input  logic      wp_ni,
  output logic      hw_prot_o,
  output logic      start_o,
  output logic      pen_o,
  output prot_lvl_e lvl_o
);
  logic      cs_q;
  logic      pend_q;
  logic      pend_pen_q;
  prot_lvl_e pend_lvl_q;
  logic      pen_q;
  prot_lvl_e lvl_q;
  logic      cs_rise;
  logic      accept;

  assign hw_prot_o = pen_q & ~wp_ni;
  assign cs_rise   = cs_ni & ~cs_q;
  assign accept    = req_i & ~cs_ni & wen_i & ~busy_i & ~hw_prot_o;
  assign start_o   = cs_rise & pend_q & ~hw_prot_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q       <= 1'b1;
      pend_q     <= 1'b0;
      pend_pen_q <= 1'b0;
      pend_lvl_q <= PROT_NONE;
    end else begin
      cs_q <= cs_ni;
      if (cs_rise)                    pend_q <= 1'b0;
      else if (!cs_ni && hw_prot_o)   pend_q <= 1'b0;  // pin abort
      else if (accept) begin
        pend_q     <= 1'b1;
        pend_pen_q <= pen_data_i;
        pend_lvl_q <= lvl_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pen_q <= 1'b0;
      lvl_q <= PROT_NONE;
    end else if (start_o) begin
      pen_q <= pend_pen_q;
      lvl_q <= pend_lvl_q;
    end
  end

  assign pen_o = pen_q;
  assign lvl_o = lvl_q;

  a_r6_only_commit_changes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_o |=> ($stable(pen_o) && $stable(lvl_o)));
  a_r8_pin_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && hw_prot_o) |=> !pend_q);
  a_r10_pen_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pen_o && !wp_ni) |=> pen_o);
endmodule

// File: rtl/sr_prot_decode.sv
module sr_prot_decode
  import sr_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  prot_lvl_e         lvl_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              prot_o
);
  localparam int unsigned TOP_HI = ADDR_W - 1;
  localparam int unsigned TOP_LO = ADDR_W - 2;

  logic [1:0] top;
  logic       unused_low;

  assign top = addr_i[TOP_HI:TOP_LO];

  generate
    if (ADDR_W > 2) begin : g_low
      assign unused_low = ^addr_i[TOP_LO-1:0];
    end else begin : g_nolow
      assign unused_low = 1'b0;
    end
  endgenerate

  always_comb begin
    unique case (lvl_i)
      PROT_NONE:    prot_o = 1'b0;
      PROT_QUARTER: prot_o = &top;
      PROT_HALF:    prot_o = top[1];
      default:      prot_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/sr_guard.sv
module sr_guard
  import sr_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wel_set_i,
  input  logic              wel_clr_i,
  input  logic              sr_wr_req_i,
  input  logic [7:0]        sr_wr_data_i,
  input  logic              cs_ni,
  input  logic              wp_ni,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  output logic              wr_permit_o,
  output logic              sr_start_o,
  output logic [7:0]        status_o
);
  logic      busy_q;
  logic      busy_fall;
  logic      wen;
  logic      pen;
  logic      hw_prot;
  logic      addr_prot;
  prot_lvl_e lvl;
  logic      unused_data;

  assign unused_data = ^{sr_wr_data_i[6:4], sr_wr_data_i[1:0], hw_prot};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= busy_i;
  end

  assign busy_fall = busy_q & ~busy_i;

  sr_wel u_wel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (wel_set_i),
    .clr_i       (wel_clr_i),
    .busy_i      (busy_i),
    .busy_fall_i (busy_fall),
    .wen_o       (wen)
  );

  sr_commit u_commit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .req_i      (sr_wr_req_i),
    .pen_data_i (sr_wr_data_i[SR_PEN]),
    .lvl_data_i (prot_lvl_e'(sr_wr_data_i[SR_LVL_HI:SR_LVL_LO])),
    .wen_i      (wen),
    .busy_i     (busy_i),
    .wp_ni      (wp_ni),
    .hw_prot_o  (hw_prot),
    .start_o    (sr_start_o),
    .pen_o      (pen),
    .lvl_o      (lvl)
  );

  sr_prot_decode #(.ADDR_W(ADDR_W)) u_decode (
    .lvl_i  (lvl),
    .addr_i (chk_addr_i),
    .prot_o (addr_prot)
  );

  assign wr_permit_o = wen & ~addr_prot;
  assign status_o    = busy_i ? {SR_W{1'b1}} : pack_status(pen, lvl, wen);

  a_r5_permit_needs_wen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_permit_o && !busy_i) |-> status_o[SR_WEN]);
  a_r4_all_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && status_o[SR_LVL_HI:SR_LVL_LO] == 2'b11) |-> !wr_permit_o);
endmodule

// File: tb/sr_guard_test.sv
`timescale 1ns/1ps
module sr_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wset = 0, wclr = 0, req = 0, cs_n = 1, wp_n = 1, busy = 0;
  logic [7:0]  data = 0;
  logic [10:0] addr = 0;
  logic        permit, start;
  logic [7:0]  status;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sr_guard uut (
    .clk_i(clk), .rst_ni(rst_n), .wel_set_i(wset), .wel_clr_i(wclr),
    .sr_wr_req_i(req), .sr_wr_data_i(data), .cs_ni(cs_n), .wp_ni(wp_n),
    .busy_i(busy), .chk_addr_i(addr), .wr_permit_o(permit),
    .sr_start_o(start), .status_o(status)
  );

  // behavioural reference
  bit       m_wen, m_pen, m_pend, m_ppen, m_csq, m_busyq;
  bit [1:0] m_lvl, m_plvl;

  function automatic bit m_prot(bit [1:0] l, int a);
    case (l)
      2'd0: return 0;
      2'd1: return a >= 1536;
      2'd2: return a >= 1024;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wen = 0; m_pen = 0; m_pend = 0; m_ppen = 0; m_csq = 1; m_busyq = 0;
      m_lvl = 0; m_plvl = 0;
    end else begin
      bit hw, rise, fall;
      hw   = m_pen && !wp_n;
      rise = cs_n && !m_csq;
      fall = m_busyq && !busy;
      if (rise && m_pend && !hw) begin m_pen = m_ppen; m_lvl = m_plvl; end
      if (rise) m_pend = 0;
      else if (!cs_n && hw) m_pend = 0;
      else if (req && !cs_n && m_wen && !busy && !hw) begin
        m_pend = 1; m_ppen = data[7]; m_plvl = data[3:2];
      end
      if (fall) m_wen = 0;
      else if (!busy) begin
        if (wclr) m_wen = 0; else if (wset) m_wen = 1;
      end
      m_csq = cs_n; m_busyq = busy;
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R3 status", status, busy ? 8'hFF : {m_pen, 3'b000, m_lvl, m_wen, 1'b0});
    chk("R5 permit", permit, m_wen && !m_prot(m_lvl, addr));
    chk("R6 start", start, cs_n && !m_csq && m_pend && !(m_pen && !wp_n));
  end

  task automatic cyc(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic pulse_set(); wset = 1; cyc(); wset = 0; endtask

  // stage status write and raise CS; returns with CS high, edge not yet taken
  task automatic stage(logic [7:0] d);
    pulse_set();
    cs_n = 0; cyc();
    req = 1; data = d; cyc();
    req = 0; cs_n = 1;
  endtask

  task automatic run_busy(int n);
    busy = 1; cyc(n);
    #1 chk("R3 busy ones", status, 8'hFF);
    busy = 0; cyc(2);
  endtask

  task automatic sr_write(logic [7:0] d);
    stage(d);
    #1 chk("R6 start pulse", start, 1);
    cyc();
    run_busy(3);
  endtask

  initial begin
    #200_000;
    if (!done) begin
      done = 1; bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1; cyc();
    #1 chk("R1 status", status, 8'h00);
    chk("R1 permit", permit, 0);

    pulse_set(); #1 chk("R2 set", status, 8'h02);
    wclr = 1; cyc(); wclr = 0; #1 chk("R2 clear", status, 8'h00);
    pulse_set(); wset = 1; wclr = 1; cyc(); wset = 0; wclr = 0;
    #1 chk("R2 clear wins", status, 8'h00);

    sr_write(8'h84);
    chk("R9 wen after busy", status, 8'h84);

    pulse_set();
    addr = 11'h5FF; #1 chk("R4 quarter below", permit, 1);
    addr = 11'h600; #1 chk("R4 quarter edge", permit, 0);
    sr_write(8'h88); pulse_set();
    addr = 11'h3FF; #1 chk("R4 half below", permit, 1);
    addr = 11'h400; #1 chk("R4 half edge", permit, 0);
    sr_write(8'h8C); pulse_set();
    addr = 11'h000; #1 chk("R4 all", permit, 0);
    sr_write(8'h80); pulse_set();
    addr = 11'h7FF; #1 chk("R4 none", permit, 1);
    wclr = 1; cyc(); wclr = 0;
    #1 chk("R5 no wen", permit, 0);

    // R10: pin-enable set, pin low: write refused
    wp_n = 0; stage(8'h00);
    #1 chk("R10 no start", start, 0);
    cyc(2); #1 chk("R10 pen kept", status, 8'h82);
    wp_n = 1; wclr = 1; cyc(); wclr = 0;

    // R7: clear pin-enable, then pin is ignored
    sr_write(8'h00);
    wp_n = 0; sr_write(8'h08);
    chk("R7 pin ignored", status, 8'h08);
    wp_n = 1;

    // R8: abort by pin while CS low
    sr_write(8'h84);
    pulse_set(); cs_n = 0; cyc();
    req = 1; data = 8'h8C; cyc(); req = 0;
    wp_n = 0; cyc(); cs_n = 1;
    #1 chk("R8 abort no start", start, 0);
    cyc(2); #1 chk("R8 level kept", status, 8'h86);
    wp_n = 1; wclr = 1; cyc(); wclr = 0;

    // R8: pin after commit has no effect
    stage(8'h88); cyc(); busy = 1; wp_n = 0; cyc(3); busy = 0; cyc(2);
    #1 chk("R8 commit kept", status, 8'h88);
    wp_n = 1;

    // R9 / R6: commands and requests during busy ignored
    busy = 1; cyc(); pulse_set(); cs_n = 0; cyc();
    req = 1; data = 8'h0C; cyc(); req = 0; busy = 0; cyc(); cs_n = 1;
    #1 chk("R6 busy request dropped", start, 0);
    cyc(2); #1 chk("R9 set ignored in busy", status, 8'h88);

    cyc(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule